// File: doc/BRIEF.md
# QoS-Aware Read/Write Burst Arbiter

This block shares one memory port between a read path and a write path. Each path raises a request for a whole burst and supplies a 4-bit priority value. At each decision point the arbiter picks one side. A decision point is a cycle in which no grant is held, or a cycle in which the current burst signals that it has finished. The grant is then held until that burst ends.

Reads win by default, because writes can wait in a buffer. That changes when the write address buffer or the write data buffer reports full. In that case the two priority values are compared. A write with strictly higher priority wins, and the arbiter pulses a drain request so that the write buffer moves its oldest entry to memory and makes room.

A balancing counter stops writes from starving. It counts read grants handed out while a write was waiting. Once it reaches a threshold, the next decision goes to the write whatever the priorities are.

Top module: `rw_burst_arb`

## Requirements
- R1: `gnt_rd` and `gnt_wr` are registered and never both high. A decision taken at a decision point appears on them from the next cycle.
- R2: A decision point is a cycle in which neither grant is high, or a cycle with `burst_done` high. Outside a decision point both grant outputs keep their values.
- R3: If only one side requests at a decision point, that side is granted. If neither side requests, both grants are low afterwards.
- R4: With both sides requesting, neither buffer full and the balancing counter below its limit, the read is granted.
- R5: With both sides requesting, at least one buffer full and the counter below its limit, the write is granted when `wr_qos` > `rd_qos` (unsigned). When `wr_qos` is equal to or lower than `rd_qos`, the read is granted.
- R6: `drain_req` is high for exactly the cycles in which the write grant starts from a decision where a read was also pending, a buffer was full and `wr_qos` > `rd_qos`. It is low in every other cycle.
- R7: Each read grant issued while a write is pending raises the balancing counter by one. At the limit `THRESH` (default 4), the next decision grants the write. A pending write is therefore passed over at most `THRESH` consecutive times.
- R8: The balancing counter returns to zero when a write is granted and in any cycle where `wr_req` is low. A write that drops its request therefore starts a new count of `THRESH` read grants.
- R9: After reset both grants and `drain_req` are low and the balancing counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | A read burst is pending |
| rd_qos | input | QOS_W | Priority of the pending read |
| wr_req | input | 1 | A write burst is pending |
| wr_qos | input | QOS_W | Priority of the incoming write |
| aw_full | input | 1 | Write address buffer full |
| wd_full | input | 1 | Write data buffer full |
| burst_done | input | 1 | The granted burst finishes in this cycle |
| gnt_rd | output | 1 | Memory port granted to the read side |
| gnt_wr | output | 1 | Memory port granted to the write side |
| drain_req | output | 1 | One-cycle request to push the oldest buffered write to memory |

## Verification
The assertions assume three things about the inputs:
- `burst_done` is high only while a grant is held.
- Requests and priority values are steady across the edge at which they are sampled.
- The full flags describe the buffer state at that edge.

The bench changes every input just after a falling edge. Outside a granted burst it holds `burst_done` low, except when it drives `burst_done` together with both requests low to return the arbiter to idle. For the counter sequences it keeps `burst_done` high for the whole run, so that every cycle is a decision point and each grant maps to one count step.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef struct packed {
    logic take_rd;
    logic take_wr;
    logic drain;
  } arb_dec_t;

endpackage

// File: rtl/arb_decide.sv
module arb_decide
  import arb_pkg::*;
#(
  parameter int QOS_W = 4
) (
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic [QOS_W-1:0] rd_qos,
  input  logic [QOS_W-1:0] wr_qos,
  input  logic             buf_full,
  input  logic             at_limit,
  output arb_dec_t         dec
);

  logic wr_beats_rd;

  assign wr_beats_rd = buf_full && (wr_qos > rd_qos);

  always_comb begin
    dec = '0;
    if (rd_req && wr_req) begin
      if (at_limit || wr_beats_rd) begin
        dec.take_wr = 1'b1;
        dec.drain   = wr_beats_rd;
      end else begin
        dec.take_rd = 1'b1;
      end
    end else if (rd_req) begin
      dec.take_rd = 1'b1;
    end else if (wr_req) begin
      dec.take_wr = 1'b1;
    end
  end

endmodule

// File: rtl/arb_balance.sv
module arb_balance #(
  parameter int THRESH = 4,
  parameter int CNT_W  = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_pt,
  input  logic             wr_req,
  input  logic             took_rd,
  input  logic             took_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);

  assign at_limit = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!wr_req) begin
      cnt <= '0;
    end else if (arb_pt) begin
      if (took_wr) begin
        cnt <= '0;
      end else if (took_rd && !at_limit) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     arb_pt,
  input  arb_dec_t dec,
  output logic     gnt_rd,
  output logic     gnt_wr,
  output logic     drain_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_rd    <= 1'b0;
      gnt_wr    <= 1'b0;
      drain_req <= 1'b0;
    end else begin
      drain_req <= 1'b0;
      if (arb_pt) begin
        gnt_rd    <= dec.take_rd;
        gnt_wr    <= dec.take_wr;
        drain_req <= dec.drain;
      end
    end
  end

endmodule

// File: rtl/rw_burst_arb.sv
module rw_burst_arb
  import arb_pkg::*;
#(
  parameter int QOS_W  = 4,
  parameter int THRESH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [QOS_W-1:0] rd_qos,
  input  logic             wr_req,
  input  logic [QOS_W-1:0] wr_qos,
  input  logic             aw_full,
  input  logic             wd_full,
  input  logic             burst_done,
  output logic             gnt_rd,
  output logic             gnt_wr,
  output logic             drain_req
);

  localparam int CNT_W = $clog2(THRESH + 1);

  logic             arb_pt;
  logic             buf_full;
  logic             at_limit;
  logic [CNT_W-1:0] bal_cnt;
  arb_dec_t         dec;

  assign buf_full = aw_full | wd_full;
  assign arb_pt   = !(gnt_rd || gnt_wr) || burst_done;

  arb_decide #(.QOS_W(QOS_W)) u_decide (
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .rd_qos   (rd_qos),
    .wr_qos   (wr_qos),
    .buf_full (buf_full),
    .at_limit (at_limit),
    .dec      (dec)
  );

  arb_balance #(.THRESH(THRESH), .CNT_W(CNT_W)) u_balance (
    .clk      (clk),
    .rst      (rst),
    .arb_pt   (arb_pt),
    .wr_req   (wr_req),
    .took_rd  (dec.take_rd),
    .took_wr  (dec.take_wr),
    .cnt      (bal_cnt),
    .at_limit (at_limit)
  );

  arb_grant_reg u_grant (
    .clk       (clk),
    .rst       (rst),
    .arb_pt    (arb_pt),
    .dec       (dec),
    .gnt_rd    (gnt_rd),
    .gnt_wr    (gnt_wr),
    .drain_req (drain_req)
  );

endmodule

// File: rtl/rw_burst_arb_chk.sv
module rw_burst_arb_chk #(
  parameter int QOS_W  = 4,
  parameter int THRESH = 4,
  parameter int CNT_W  = $clog2(THRESH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic [QOS_W-1:0] rd_qos,
  input logic             wr_req,
  input logic [QOS_W-1:0] wr_qos,
  input logic             aw_full,
  input logic             wd_full,
  input logic             burst_done,
  input logic             gnt_rd,
  input logic             gnt_wr,
  input logic             drain_req,
  input logic [CNT_W-1:0] bal_cnt
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(THRESH);

  logic at_pt;
  logic full;

  assign at_pt = !(gnt_rd || gnt_wr) || burst_done;
  assign full  = aw_full || wd_full;

  a_r1_one_side: assert property (@(posedge clk) disable iff (rst)
    !(gnt_rd && gnt_wr));

  a_r2_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (gnt_rd || gnt_wr) && !burst_done |=> $stable({gnt_rd, gnt_wr}));

  a_r4_read_first: assert property (@(posedge clk) disable iff (rst)
    at_pt && rd_req && wr_req && !full && bal_cnt < LIM |=> gnt_rd);

  a_r5_qos_write: assert property (@(posedge clk) disable iff (rst)
    at_pt && rd_req && wr_req && full && wr_qos > rd_qos |=> gnt_wr && drain_req);

  a_r6_drain_with_write: assert property (@(posedge clk) disable iff (rst)
    drain_req |-> gnt_wr);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    bal_cnt <= LIM);

  a_r7_forced_write: assert property (@(posedge clk) disable iff (rst)
    at_pt && wr_req && bal_cnt == LIM |=> gnt_wr);

  a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> bal_cnt == '0);

endmodule

bind rw_burst_arb rw_burst_arb_chk #(.QOS_W(QOS_W), .THRESH(THRESH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .rd_qos     (rd_qos),
  .wr_req     (wr_req),
  .wr_qos     (wr_qos),
  .aw_full    (aw_full),
  .wd_full    (wd_full),
  .burst_done (burst_done),
  .gnt_rd     (gnt_rd),
  .gnt_wr     (gnt_wr),
  .drain_req  (drain_req),
  .bal_cnt    (bal_cnt)
);

// File: tb/rw_burst_arb_tb_top.sv
module rw_burst_arb_tb_top;

  localparam int QW = 4;
  localparam int TH = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          rd_req, wr_req, aw_full, wd_full, burst_done;
  logic [QW-1:0] rd_qos, wr_qos;
  logic          gnt_rd, gnt_wr, drain_req;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  rw_burst_arb #(.QOS_W(QW), .THRESH(TH)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .rd_qos     (rd_qos),
    .wr_req     (wr_req),
    .wr_qos     (wr_qos),
    .aw_full    (aw_full),
    .wd_full    (wd_full),
    .burst_done (burst_done),
    .gnt_rd     (gnt_rd),
    .gnt_wr     (gnt_wr),
    .drain_req  (drain_req)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // exp packs {gnt_wr, gnt_rd, drain_req}
  task automatic chk(string tag, logic [2:0] exp);
    logic [2:0] act;
    act = {gnt_wr, gnt_rd, drain_req};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got {wr,rd,drain}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    rd_req = 0; wr_req = 0; aw_full = 0; wd_full = 0;
    burst_done = 1;
    step();
    burst_done = 0;
  endtask

  task automatic t_reset();
    rst = 1; rd_req = 0; wr_req = 0; aw_full = 0; wd_full = 0;
    burst_done = 0; rd_qos = 0; wr_qos = 0;
    step(); step();
    rst = 0;
    chk("R9 reset state", 3'b000);
    step();
    chk("R3 no request keeps idle", 3'b000);
  endtask

  task automatic t_single();
    rd_req = 1; step();
    chk("R3 read alone", 3'b010);
    go_idle();
    chk("R3 back to idle", 3'b000);
    wr_req = 1; wr_qos = 0; step();
    chk("R3 write alone", 3'b100);
    go_idle();
  endtask

  task automatic t_read_first();
    rd_req = 1; wr_req = 1; rd_qos = 0; wr_qos = 15; step();
    chk("R4 read wins with buffers not full", 3'b010);
    go_idle();
  endtask

  task automatic t_hold();
    rd_req = 1; wr_req = 0; step();
    chk("R1 read grant", 3'b010);
    rd_req = 0; wr_req = 1; aw_full = 1; wr_qos = 15; rd_qos = 0;
    step(); step();
    chk("R2 grant held until burst_done", 3'b010);
    burst_done = 1; step(); burst_done = 0;
    chk("R2 rearbitrate at burst_done", 3'b100);
    step();
    chk("R6 no drain when read absent", 3'b100);
    go_idle();
  endtask

  task automatic t_qos();
    rd_req = 1; wr_req = 1; aw_full = 1; rd_qos = 3; wr_qos = 9; step();
    chk("R5 higher write qos wins, R6 drain", 3'b101);
    step();
    chk("R6 drain lasts one cycle", 3'b100);
    go_idle();
    rd_req = 1; wr_req = 1; wd_full = 1; rd_qos = 7; wr_qos = 7; step();
    chk("R5 equal qos goes to read", 3'b010);
    go_idle();
    rd_req = 1; wr_req = 1; wd_full = 1; rd_qos = 10; wr_qos = 2; step();
    chk("R5 lower write qos loses", 3'b010);
    go_idle();
  endtask

  task automatic t_starve();
    rd_req = 1; wr_req = 1; rd_qos = 0; wr_qos = 0;
    burst_done = 1;
    for (int i = 0; i < TH + 2; i++) begin
      step();
      if (i == TH) chk("R7 forced write after limit", 3'b100);
      else         chk("R7 read while under limit", 3'b010);
    end
    go_idle();
  endtask

  task automatic t_starve_full();
    rd_req = 1; wr_req = 1; wd_full = 1; rd_qos = 12; wr_qos = 2;
    burst_done = 1;
    for (int i = 0; i < TH + 1; i++) begin
      step();
      if (i == TH) chk("R7 forced write ignores qos, no drain", 3'b100);
      else         chk("R7 qos read under limit", 3'b010);
    end
    go_idle();
  endtask

  task automatic t_clear();
    rd_req = 1; wr_req = 1; rd_qos = 0; wr_qos = 0;
    burst_done = 1;
    step(); step();
    wr_req = 0; step();
    chk("R8 read alone while write drops", 3'b010);
    wr_req = 1;
    for (int i = 0; i < TH + 1; i++) begin
      step();
      if (i == TH) chk("R8 write after full recount", 3'b100);
      else         chk("R8 recount reads", 3'b010);
    end
    go_idle();
  endtask

  initial begin
    t_reset();
    t_single();
    t_read_first();
    t_hold();
    t_qos();
    t_starve();
    t_starve_full();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule